// File: doc/BRIEF.md
# Low-Power Display Mode Sequencer

This block moves a display-driver device between full operation and a sleep state. In the sleep state only display refresh and timekeeping keep running. A host requests entry over one handshake pin, which is the shared power or chip-select line, together with a small control register. While the device sleeps, the block removes the power-domain enable of the main logic. It then watches three wake sources: a real-time-clock alarm, a clock-oscillator failure and a port-match event. On any exit it treats the wake as a reset. It pulses a port-configuration reset, sets a reset-complete flag and raises the interrupt line until the host clears it.

The handshake pin and the three wake inputs each pass through a two-flop synchroniser before the state machine sees them. Wake events are latched. A wake event that arrives while entry is in progress is therefore kept. At the moment the pin rises it blocks the entry. The control register also selects an external low-frequency clock in place of the internal real-time-clock oscillator, and it can switch the real-time clock off.

Top module: `lpm_sequencer`

## Requirements
- R1: Entry follows a fixed order. First the handshake pin goes low, and the mode reads 1 (entering). Then, while the pin is still low, the host writes the control register with bit 0 (display enable) set. Then the pin rises, and the mode reads 2 (low power).
- R2: Entry is refused if an enabled wake event is latched, or the reset-complete flag is set, when the pin rises. In that case the mode returns to 0 (normal) and `irq` stays high. An event that arrives while the mode reads 1 is latched and also blocks entry.
- R3: In low power the block stays put until an enabled alarm (input 0), oscillator failure (input 1) or port match (input 2) occurs. Port match wakes the device only if control bit 1 was set when the device entered; a write to bit 1 made during low power has no effect.
- R4: Driving the handshake pin low while in low power forces a wake, even when no wake event is present.
- R5: Every wake sets the reset-complete flag, which drives `irq` high. The flag clears only when `irq_clr` is high. If a clear and a wake fall in the same cycle, the wake wins.
- R6: `port_cfg_rst` is high for exactly one cycle per wake and is never high otherwise.
- R7: With control bit 3 set (real-time clock off), the alarm and oscillator-fail inputs are ignored and cause no wake.
- R8: `main_pwr_en` is low only while the mode reads 2. `refresh_en` follows control bit 0 and stays high through low power.
- R9: `lf_clk_sel` follows control bit 2 (use the external low-frequency clock).
- R10: `stat_mode` encodes normal=0, entering=1, low power=2, waking=3. `stat_cause` records the source of the latest wake: 0 host or none, 1 alarm, 2 oscillator failure, 3 port match. When several sources are present, alarm has priority over oscillator failure, which has priority over port match.
- R11: After reset the mode is 0, `main_pwr_en` is 1, `irq` is 0, the cause is 0 and every control bit is 0.
- R12: A control write with bit 0 set that is made before the pin goes low does not arm entry. The next rising edge of the pin returns the mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the low-power domain |
| rst | input | 1 | Synchronous active-high reset |
| hs_pin | input | 1 | Handshake pin (power / chip select), asynchronous, idles high |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write data: bit0 display enable, bit1 port wake enable, bit2 external clock select, bit3 RTC off |
| irq_clr | input | 1 | Clears the reset-complete flag and latched wake events |
| wake_alarm | input | 1 | Clock alarm event, asynchronous |
| wake_oscfail | input | 1 | Clock oscillator failure event, asynchronous |
| wake_port | input | 1 | Port-match event, asynchronous |
| main_pwr_en | output | 1 | Power-domain enable for logic outside the low-power block |
| refresh_en | output | 1 | Display refresh enable |
| lf_clk_sel | output | 1 | Selects the external low-frequency clock |
| port_cfg_rst | output | 1 | One-cycle reset of port configuration and state on wake |
| irq | output | 1 | Interrupt line |
| stat_mode | output | 2 | Current mode code |
| stat_cause | output | 2 | Cause of the most recent wake |

## Verification
A forced wake and a host clear of the reset-complete flag can land in the same clock cycle. The flag is set in the waking cycle while the clear strobe acts at the same edge. The bench drives the handshake pin low from low power. It then counts the synchroniser and state-register stages and raises `irq_clr` for exactly the cycle in which the mode reads 3. After that edge `irq` must still be high and the mode must be back to normal or entering. A second overlap is also checked: a wake event arriving while entry is in progress must be latched and must block entry when the pin rises.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int NUM_WAKE = 3;
    localparam int WK_ALARM = 0;
    localparam int WK_OSCF  = 1;
    localparam int WK_PORT  = 2;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_ENTER  = 2'd1,
        MODE_LOWPWR = 2'd2,
        MODE_WAKE   = 2'd3
    } lpm_mode_e;

    typedef enum logic [1:0] {
        CAUSE_HOST  = 2'd0,
        CAUSE_ALARM = 2'd1,
        CAUSE_OSCF  = 2'd2,
        CAUSE_PORT  = 2'd3
    } lpm_cause_e;

    // Control register layout: bit0 display enable ... bit3 RTC off
    typedef struct packed {
        logic rtc_off;
        logic clk_byp;
        logic port_wake_en;
        logic disp_en;
    } lpm_ctl_t;

    function automatic lpm_cause_e pick_cause(input logic [NUM_WAKE-1:0] ev);
        if (ev[WK_ALARM])     return CAUSE_ALARM;
        else if (ev[WK_OSCF]) return CAUSE_OSCF;
        else if (ev[WK_PORT]) return CAUSE_PORT;
        else                  return CAUSE_HOST;
    endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lpm_wake.sv
module lpm_wake
    import lpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_WAKE-1:0] ev_s,
    input  logic                rtc_off,
    input  logic                port_en,
    input  logic                in_lp,
    input  logic                clr,
    output logic [NUM_WAKE-1:0] pend_en
);
    logic [NUM_WAKE-1:0] pend;
    logic [NUM_WAKE-1:0] en;
    logic                pm_armed;

    // port-match permission is frozen at the moment low power is entered
    always_ff @(posedge clk) begin
        if (rst)         pm_armed <= 1'b0;
        else if (!in_lp) pm_armed <= port_en;
    end

    always_comb begin
        en           = '0;
        en[WK_ALARM] = !rtc_off;
        en[WK_OSCF]  = !rtc_off;
        en[WK_PORT]  = in_lp ? pm_armed : port_en;
    end

    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst)      pend[g] <= 1'b0;
            else if (clr) pend[g] <= ev_s[g] & en[g];
            else          pend[g] <= pend[g] | (ev_s[g] & en[g]);
        end
    end

    assign pend_en = pend & en;

    AST_RTC_OFF_MASK: assert property (@(posedge clk) disable iff (rst)
        ($past(rtc_off) && !$past(pend[WK_ALARM])) |-> !pend[WK_ALARM]); // R7

    AST_PORT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (in_lp && $past(in_lp) && !$past(pm_armed) && !$past(pend[WK_PORT]))
        |-> !pend[WK_PORT]); // R3
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hs_s,
    input  logic                arm_wr,
    input  logic [NUM_WAKE-1:0] pend_en,
    input  logic                irq_clr,
    output lpm_mode_e           mode,
    output lpm_cause_e          cause,
    output logic                rc_flag,
    output logic                consume,
    output logic                main_pwr_en,
    output logic                port_rst
);
    lpm_mode_e state, nxt;
    logic      armed_ok;
    logic      pend_any;

    assign pend_any = |pend_en;

    always_comb begin
        nxt = state;
        case (state)
            MODE_NORMAL: if (!hs_s) nxt = MODE_ENTER;
            MODE_ENTER:  if (hs_s)  nxt = (armed_ok && !pend_any && !rc_flag)
                                          ? MODE_LOWPWR : MODE_NORMAL;
            MODE_LOWPWR: if (pend_any || !hs_s) nxt = MODE_WAKE;
            default:     nxt = MODE_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= MODE_NORMAL;
            armed_ok <= 1'b0;
            cause    <= CAUSE_HOST;
            rc_flag  <= 1'b0;
        end else begin
            state    <= nxt;
            armed_ok <= (state == MODE_ENTER) && (armed_ok || arm_wr);
            if (state == MODE_WAKE) cause <= pick_cause(pend_en);
            if (state == MODE_WAKE) rc_flag <= 1'b1;
            else if (irq_clr)       rc_flag <= 1'b0;
        end
    end

    assign mode        = state;
    assign consume     = (state == MODE_WAKE);
    assign port_rst    = (state == MODE_WAKE);
    assign main_pwr_en = (state != MODE_LOWPWR);

    AST_ENTRY_PATH: assert property (@(posedge clk) disable iff (rst)
        (state == MODE_LOWPWR && $past(state) != MODE_LOWPWR)
        |-> ($past(state) == MODE_ENTER && $past(armed_ok))); // R1

    AST_NO_ENTRY_PENDING: assert property (@(posedge clk) disable iff (rst)
        (state == MODE_ENTER && pend_any) |=> state != MODE_LOWPWR); // R2

    AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (state == MODE_LOWPWR && !pend_any && hs_s) |=> state == MODE_LOWPWR); // R3

    AST_HOST_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state == MODE_LOWPWR && !hs_s) |=> state == MODE_WAKE); // R4

    AST_WAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (state == MODE_WAKE) |=> rc_flag); // R5
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hs_pin,
    input  logic       ctl_we,
    input  logic [3:0] ctl_wdata,
    input  logic       irq_clr,
    input  logic       wake_alarm,
    input  logic       wake_oscfail,
    input  logic       wake_port,
    output logic       main_pwr_en,
    output logic       refresh_en,
    output logic       lf_clk_sel,
    output logic       port_cfg_rst,
    output logic       irq,
    output logic [1:0] stat_mode,
    output logic [1:0] stat_cause
);
    lpm_ctl_t            ctl_q;
    logic                hs_s;
    logic [NUM_WAKE-1:0] ev_raw, ev_s, pend_en;
    lpm_mode_e           mode;
    lpm_cause_e          cause;
    logic                rc_flag, consume;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_we) ctl_q <= lpm_ctl_t'(ctl_wdata);
    end

    assign ev_raw = {wake_port, wake_oscfail, wake_alarm};

    lpm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hs_sync (
        .clk(clk), .rst(rst), .d(hs_pin), .q(hs_s)
    );

    lpm_sync #(.WIDTH(NUM_WAKE), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ev_sync (
        .clk(clk), .rst(rst), .d(ev_raw), .q(ev_s)
    );

    lpm_wake u_wake (
        .clk(clk), .rst(rst), .ev_s(ev_s),
        .rtc_off(ctl_q.rtc_off), .port_en(ctl_q.port_wake_en),
        .in_lp(mode == MODE_LOWPWR), .clr(irq_clr | consume),
        .pend_en(pend_en)
    );

    lpm_fsm u_fsm (
        .clk(clk), .rst(rst), .hs_s(hs_s),
        .arm_wr(ctl_we & ctl_wdata[0]),
        .pend_en(pend_en), .irq_clr(irq_clr),
        .mode(mode), .cause(cause), .rc_flag(rc_flag), .consume(consume),
        .main_pwr_en(main_pwr_en), .port_rst(port_cfg_rst)
    );

    assign irq        = rc_flag | (|pend_en);
    assign refresh_en = ctl_q.disp_en;
    assign lf_clk_sel = ctl_q.clk_byp;
    assign stat_mode  = mode;
    assign stat_cause = cause;

    AST_PORT_RST_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        port_cfg_rst |=> !port_cfg_rst); // R6

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
        (rc_flag && !irq_clr) |=> rc_flag); // R5
endmodule

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;
    logic       clk = 1'b0;
    logic       rst;
    logic       hs_pin, ctl_we, irq_clr;
    logic [3:0] ctl_wdata;
    logic       wake_alarm, wake_oscfail, wake_port;
    logic       main_pwr_en, refresh_en, lf_clk_sel, port_cfg_rst, irq;
    logic [1:0] stat_mode, stat_cause;

    int checks = 0;
    int errors = 0;
    int rst_pulses = 0;

    always #5 clk = ~clk;

    lpm_sequencer dut (
        .clk(clk), .rst(rst), .hs_pin(hs_pin), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .irq_clr(irq_clr), .wake_alarm(wake_alarm), .wake_oscfail(wake_oscfail),
        .wake_port(wake_port), .main_pwr_en(main_pwr_en), .refresh_en(refresh_en),
        .lf_clk_sel(lf_clk_sel), .port_cfg_rst(port_cfg_rst), .irq(irq),
        .stat_mode(stat_mode), .stat_cause(stat_cause)
    );

    always @(posedge clk) if (port_cfg_rst === 1'b1) rst_pulses++;

    typedef struct {
        string      tag;
        logic [1:0] mode;
        logic       pwr;
        logic       irq;
        logic [1:0] cause;
    } exp_t;

    exp_t sbq[$];

    // monitor: compare queued expectations against the ports
    initial forever begin
        @(negedge clk);
        while (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (stat_mode !== e.mode || main_pwr_en !== e.pwr ||
                irq !== e.irq || stat_cause !== e.cause) begin
                errors++;
                $display("FAIL %s: mode=%0d pwr=%0b irq=%0b cause=%0d expected mode=%0d pwr=%0b irq=%0b cause=%0d",
                         e.tag, stat_mode, main_pwr_en, irq, stat_cause,
                         e.mode, e.pwr, e.irq, e.cause);
            end
        end
    end

    task automatic expect_st(input string tag, input logic [1:0] m, input logic p,
                             input logic i, input logic [1:0] c);
        exp_t e;
        e.tag = tag; e.mode = m; e.pwr = p; e.irq = i; e.cause = c;
        sbq.push_back(e);
        wait (sbq.size() == 0);
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [3:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        settle(2);
    endtask

    task automatic pulse_ev(input int which);
        @(negedge clk);
        if (which == 0) wake_alarm = 1'b1;
        if (which == 1) wake_oscfail = 1'b1;
        if (which == 2) wake_port = 1'b1;
        if (which == 3) begin wake_alarm = 1'b1; wake_oscfail = 1'b1; end
        settle(3);
        wake_alarm = 1'b0; wake_oscfail = 1'b0; wake_port = 1'b0;
        settle(6);
    endtask

    task automatic enter_lp(input logic [3:0] cfg);
        @(negedge clk); hs_pin = 1'b0;
        settle(5);
        wr_ctl(cfg);
        settle(2);
        hs_pin = 1'b1;
        settle(5);
    endtask

    task automatic host_wake();
        @(negedge clk); hs_pin = 1'b0;
        settle(8);
        hs_pin = 1'b1;
        settle(5);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        rst = 1'b1; hs_pin = 1'b1; ctl_we = 1'b0; ctl_wdata = 4'h0; irq_clr = 1'b0;
        wake_alarm = 1'b0; wake_oscfail = 1'b0; wake_port = 1'b0;
        settle(4);
        rst = 1'b0;
        settle(2);

        // R11 reset state
        expect_st("R11 reset", 2'd0, 1'b1, 1'b0, 2'd0);
        check_val("R11 refresh_en", int'(refresh_en), 0);
        check_val("R11 lf_clk_sel", int'(lf_clk_sel), 0);

        // R12 early write does not arm
        wr_ctl(4'b0001);
        @(negedge clk); hs_pin = 1'b0;
        settle(5);
        expect_st("R1 entering code", 2'd1, 1'b1, 1'b0, 2'd0);
        hs_pin = 1'b1;
        settle(5);
        expect_st("R12 early write", 2'd0, 1'b1, 1'b0, 2'd0);

        // R1 / R8 proper entry
        enter_lp(4'b0001);
        expect_st("R1 entry", 2'd2, 1'b0, 1'b0, 2'd0);
        check_val("R8 refresh in low power", int'(refresh_en), 1);

        // R4 / R5 / R6 host wake
        base = rst_pulses;
        @(negedge clk); hs_pin = 1'b0;
        settle(8);
        expect_st("R4 host wake", 2'd1, 1'b1, 1'b1, 2'd0);
        check_val("R6 one pulse", rst_pulses - base, 1);
        hs_pin = 1'b1;
        settle(5);
        expect_st("R2 refused while flag set", 2'd0, 1'b1, 1'b1, 2'd0);
        clear_irq();
        expect_st("R5 clear", 2'd0, 1'b1, 1'b0, 2'd0);

        // R3 / R10 alarm wake
        enter_lp(4'b0001);
        pulse_ev(0);
        expect_st("R10 alarm cause", 2'd0, 1'b1, 1'b1, 2'd1);
        clear_irq();

        // R3 / R10 oscillator failure
        enter_lp(4'b0001);
        pulse_ev(1);
        expect_st("R10 oscfail cause", 2'd0, 1'b1, 1'b1, 2'd2);
        clear_irq();

        // R10 priority alarm over oscfail
        enter_lp(4'b0001);
        pulse_ev(3);
        expect_st("R10 priority", 2'd0, 1'b1, 1'b1, 2'd1);
        clear_irq();

        // R3 port match not armed at entry; late write ignored
        enter_lp(4'b0001);
        wr_ctl(4'b0011);
        pulse_ev(2);
        expect_st("R3 port not armed", 2'd2, 1'b0, 1'b0, 2'd1);
        host_wake();
        expect_st("R4 host cause", 2'd0, 1'b1, 1'b1, 2'd0);
        clear_irq();

        // R3 port match armed at entry
        enter_lp(4'b0011);
        pulse_ev(2);
        expect_st("R3 port armed", 2'd0, 1'b1, 1'b1, 2'd3);
        clear_irq();

        // R7 real-time clock off
        enter_lp(4'b1001);
        pulse_ev(0);
        pulse_ev(1);
        expect_st("R7 rtc off", 2'd2, 1'b0, 1'b0, 2'd3);
        host_wake();
        clear_irq();

        // R9 external clock select
        wr_ctl(4'b0100);
        settle(1);
        check_val("R9 lf_clk_sel", int'(lf_clk_sel), 1);
        check_val("R8 refresh follows bit0", int'(refresh_en), 0);
        wr_ctl(4'b0000);

        // R2 event during entering blocks entry
        @(negedge clk); hs_pin = 1'b0;
        settle(5);
        pulse_ev(0);
        wr_ctl(4'b0001);
        settle(2);
        hs_pin = 1'b1;
        settle(5);
        expect_st("R2 pending refusal", 2'd0, 1'b1, 1'b1, 2'd0);
        clear_irq();
        expect_st("R2 cleared", 2'd0, 1'b1, 1'b0, 2'd0);

        // R5 collision: clear in the waking cycle, set wins
        enter_lp(4'b0001);
        base = rst_pulses;
        @(negedge clk); hs_pin = 1'b0;
        settle(3);
        irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        settle(4);
        expect_st("R5 set wins", 2'd1, 1'b1, 1'b1, 2'd0);
        check_val("R6 collision pulse", rst_pulses - base, 1);
        hs_pin = 1'b1;
        settle(5);
        clear_irq();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule